// File: doc/BRIEF.md
# Hardware Transaction Sequencer

This block is the control sequencer for hardware transactions on an out-of-order core that keeps transactional state in its existing reorder and memory buffers. No cache-side versioning is involved. When a transaction is requested, the sequencer holds dispatch until every older instruction has retired and both the load and store buffers are empty. At that point the architectural register file is a clean checkpoint. The sequencer then freezes retirement and pins the memory buffers, and the transactional region runs.

A transaction ends in one of two ways:
- **Commit.** The store write set is published to the level-one data cache. Retirement is then released.
- **Abort.** An abort can come from a load-buffer or store-buffer overflow, a snoop conflict, or an explicit request. The sequencer uses the same machine-clear path as a branch mispredict: a one-cycle pipeline flush plus a checkpoint restore.

Nested begin requests are folded into a depth counter. Only the outermost end commits. A result code reports how the most recent transaction ended.

Top module: `htm_txn_ctrl`

## Requirements
- R1: After reset the block is idle: dispatchStall, retireLock, memBufLock, drainWs, pipeFlush, ckptRestore and txActive are all 0, and statusCode is 0 (none).
- R2: A beginReq while idle raises dispatchStall on the next cycle. The stall holds while inflightCnt is non-zero or either buffer-empty flag is low. In the cycle after all three conditions are met, txActive is 1 and dispatchStall is 0.
- R3: While txActive is 1, retireLock and memBufLock are 1 and dispatchStall is 0.
- R4: An outermost endReq moves the block to write-set drain. In drain, drainWs, retireLock, memBufLock and dispatchStall are 1. Drain holds until drainDone. On the next cycle all outputs are 0 and statusCode is 1 (committed).
- R5: An abort cause while active drives pipeFlush and ckptRestore high for exactly one cycle. The block is idle on the cycle after that.
- R6: The abort code is 2 for overflow (loadOverflow, storeOverflow, or nest overflow), 3 for snoopConflict, and 4 for abortReq. When causes coincide, priority is overflow, then conflict, then explicit.
- R7: An abort cause in the same cycle as endReq wins: the block flushes and does not drain.
- R8: Each beginReq while active deepens nesting, and each endReq while deeper than one only unwinds one level. A begin and an end in the same cycle leave the depth unchanged. A beginReq when the depth is already DEPTH_MAX aborts with code 2.
- R9: Overflow, conflict and abortReq inputs have no effect while idle, while waiting for the window to empty, or during write-set drain.
- R10: statusCode holds its value until the next beginReq is accepted while idle, which clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| beginReq | input | 1 | Transaction begin request |
| endReq | input | 1 | Transaction end request |
| abortReq | input | 1 | Explicit abort request |
| inflightCnt | input | CNT_W | Instructions currently in the reorder window |
| loadBufEmpty | input | 1 | Load buffer holds no entries |
| storeBufEmpty | input | 1 | Store buffer holds no entries |
| loadOverflow | input | 1 | Load buffer could not allocate |
| storeOverflow | input | 1 | Store buffer could not allocate |
| snoopConflict | input | 1 | Remote access hit a tracked buffer entry |
| drainDone | input | 1 | Write set fully written to L1 |
| dispatchStall | output | 1 | Hold instruction dispatch |
| retireLock | output | 1 | Block retirement |
| memBufLock | output | 1 | Pin load and store buffer entries |
| drainWs | output | 1 | Write the store write set to L1 |
| pipeFlush | output | 1 | Machine clear of all out-of-order buffers |
| ckptRestore | output | 1 | Reload the checkpointed architectural registers |
| txActive | output | 1 | Transactional region running |
| statusCode | output | 3 | 0 none, 1 committed, 2 overflow, 3 conflict, 4 explicit |

## Verification
The bench builds the block with DEPTH_MAX of 3 and the full reorder capacity of 168. A nesting depth of 3 lets every depth from 1 up to the overflow point be entered and unwound completely in a few cycles. The full-width counter lets every non-zero in-flight count be walked while the stall is held. Abort priority is checked against all combinations of the three abort causes, each with and without a simultaneous end. All eight combinations of the empty conditions are also swept during the pre-transaction wait.

// File: rtl/htm_txn_pkg.sv
package htm_txn_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAIN_PRE,
    ST_ACTIVE,
    ST_COMMIT_DRAIN,
    ST_ABORT_FLUSH
  } txnState_e;

  typedef enum logic [2:0] {
    STS_NONE           = 3'd0,
    STS_COMMITTED      = 3'd1,
    STS_ABORT_OVF      = 3'd2,
    STS_ABORT_CONFLICT = 3'd3,
    STS_ABORT_EXPLICIT = 3'd4
  } txnStatus_e;

  typedef struct packed {
    logic       depthInit;
    logic       depthInc;
    logic       depthDec;
    logic       statusWr;
    txnStatus_e statusVal;
  } dpCtl_t;

endpackage

// File: rtl/htm_txn_dp.sv
module htm_txn_dp
  import htm_txn_pkg::*;
#(
  parameter int DEPTH_MAX = 7,
  localparam int DEPTH_W = $clog2(DEPTH_MAX + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtl_t     ctl,
  output logic       depthIsOne,
  output logic       depthAtMax,
  output logic [2:0] statusCode
);

  logic [DEPTH_W-1:0] depthQ;
  txnStatus_e         statusQ;

  // Nesting depth: loaded with one on the outermost begin
  always_ff @(posedge clk) begin
    if (!rstN) begin
      depthQ <= '0;
    end else if (ctl.depthInit) begin
      depthQ <= DEPTH_W'(1);
    end else if (ctl.depthInc) begin
      depthQ <= depthQ + DEPTH_W'(1);
    end else if (ctl.depthDec) begin
      depthQ <= depthQ - DEPTH_W'(1);
    end
  end

  // Result of the most recent transaction
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= STS_NONE;
    end else if (ctl.statusWr) begin
      statusQ <= ctl.statusVal;
    end
  end

  assign depthIsOne = (depthQ == DEPTH_W'(1));
  assign depthAtMax = (depthQ == DEPTH_W'(DEPTH_MAX));
  assign statusCode = statusQ;

endmodule

// File: rtl/htm_txn_fsm.sv
module htm_txn_fsm
  import htm_txn_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             beginReq,
  input  logic             endReq,
  input  logic             abortReq,
  input  logic [CNT_W-1:0] inflightCnt,
  input  logic             loadBufEmpty,
  input  logic             storeBufEmpty,
  input  logic             loadOverflow,
  input  logic             storeOverflow,
  input  logic             snoopConflict,
  input  logic             drainDone,
  input  logic             depthIsOne,
  input  logic             depthAtMax,
  output dpCtl_t           ctl,
  output logic             dispatchStall,
  output logic             retireLock,
  output logic             memBufLock,
  output logic             drainWs,
  output logic             pipeFlush,
  output logic             ckptRestore,
  output logic             txActive
);

  txnState_e stateQ, stateD;
  logic      windowClean;
  logic      nestOnly;
  logic      unnestOnly;
  logic      ovfHit;

  assign windowClean = (inflightCnt == '0) && loadBufEmpty && storeBufEmpty;
  assign nestOnly    = beginReq && !endReq;
  assign unnestOnly  = endReq && !beginReq;
  assign ovfHit      = loadOverflow || storeOverflow || (nestOnly && depthAtMax);

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD        = stateQ;
    ctl           = '0;
    ctl.statusVal = STS_NONE;
    unique case (stateQ)
      ST_IDLE: begin
        if (beginReq) begin
          stateD        = ST_DRAIN_PRE;
          ctl.depthInit = 1'b1;
          ctl.statusWr  = 1'b1;
          ctl.statusVal = STS_NONE;
        end
      end
      ST_DRAIN_PRE: begin
        if (windowClean) stateD = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        // abort causes outrank any end request in the same cycle
        if (ovfHit) begin
          stateD        = ST_ABORT_FLUSH;
          ctl.statusWr  = 1'b1;
          ctl.statusVal = STS_ABORT_OVF;
        end else if (snoopConflict) begin
          stateD        = ST_ABORT_FLUSH;
          ctl.statusWr  = 1'b1;
          ctl.statusVal = STS_ABORT_CONFLICT;
        end else if (abortReq) begin
          stateD        = ST_ABORT_FLUSH;
          ctl.statusWr  = 1'b1;
          ctl.statusVal = STS_ABORT_EXPLICIT;
        end else if (nestOnly) begin
          ctl.depthInc = 1'b1;
        end else if (unnestOnly) begin
          if (depthIsOne) stateD = ST_COMMIT_DRAIN;
          else            ctl.depthDec = 1'b1;
        end
      end
      ST_COMMIT_DRAIN: begin
        if (drainDone) begin
          stateD        = ST_IDLE;
          ctl.statusWr  = 1'b1;
          ctl.statusVal = STS_COMMITTED;
        end
      end
      ST_ABORT_FLUSH: begin
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign txActive      = (stateQ == ST_ACTIVE);
  assign drainWs       = (stateQ == ST_COMMIT_DRAIN);
  assign pipeFlush     = (stateQ == ST_ABORT_FLUSH);
  assign ckptRestore   = (stateQ == ST_ABORT_FLUSH);
  assign retireLock    = txActive || drainWs;
  assign memBufLock    = txActive || drainWs;
  assign dispatchStall = (stateQ == ST_DRAIN_PRE) || drainWs || pipeFlush;

endmodule

// File: rtl/htm_txn_ctrl.sv
module htm_txn_ctrl
  import htm_txn_pkg::*;
#(
  parameter int ROB_SIZE  = 168,
  parameter int DEPTH_MAX = 7,
  localparam int CNT_W = $clog2(ROB_SIZE + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             beginReq,
  input  logic             endReq,
  input  logic             abortReq,
  input  logic [CNT_W-1:0] inflightCnt,
  input  logic             loadBufEmpty,
  input  logic             storeBufEmpty,
  input  logic             loadOverflow,
  input  logic             storeOverflow,
  input  logic             snoopConflict,
  input  logic             drainDone,
  output logic             dispatchStall,
  output logic             retireLock,
  output logic             memBufLock,
  output logic             drainWs,
  output logic             pipeFlush,
  output logic             ckptRestore,
  output logic             txActive,
  output logic [2:0]       statusCode
);

  dpCtl_t ctl;
  logic   depthIsOne;
  logic   depthAtMax;

  htm_txn_fsm #(.CNT_W(CNT_W)) fsm_i (
    .clk(clk), .rstN(rstN),
    .beginReq(beginReq), .endReq(endReq), .abortReq(abortReq),
    .inflightCnt(inflightCnt),
    .loadBufEmpty(loadBufEmpty), .storeBufEmpty(storeBufEmpty),
    .loadOverflow(loadOverflow), .storeOverflow(storeOverflow),
    .snoopConflict(snoopConflict), .drainDone(drainDone),
    .depthIsOne(depthIsOne), .depthAtMax(depthAtMax),
    .ctl(ctl),
    .dispatchStall(dispatchStall), .retireLock(retireLock),
    .memBufLock(memBufLock), .drainWs(drainWs),
    .pipeFlush(pipeFlush), .ckptRestore(ckptRestore),
    .txActive(txActive)
  );

  htm_txn_dp #(.DEPTH_MAX(DEPTH_MAX)) dp_i (
    .clk(clk), .rstN(rstN),
    .ctl(ctl),
    .depthIsOne(depthIsOne), .depthAtMax(depthAtMax),
    .statusCode(statusCode)
  );

endmodule

// File: rtl/htm_txn_chk.sv
module htm_txn_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             endReq,
  input logic             abortReq,
  input logic [CNT_W-1:0] inflightCnt,
  input logic             loadOverflow,
  input logic             storeOverflow,
  input logic             snoopConflict,
  input logic             drainDone,
  input logic             dispatchStall,
  input logic             retireLock,
  input logic             memBufLock,
  input logic             drainWs,
  input logic             pipeFlush,
  input logic             ckptRestore,
  input logic             txActive,
  input logic [2:0]       statusCode
);

  // R2: pre-transaction stall persists while the window is still occupied
  p_stall_until_empty_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dispatchStall && !drainWs && !pipeFlush && inflightCnt != '0) |=> dispatchStall);

  // R3: locks held throughout the transactional region
  p_lock_active_r3: assert property (@(posedge clk) disable iff (!rstN)
    txActive |-> (retireLock && memBufLock && !dispatchStall));

  // R4: drain keeps retirement locked and persists until done
  p_drain_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (drainWs && !drainDone) |=> (drainWs && retireLock && memBufLock));

  // R4: leaving drain reports commit
  p_commit_status_r4: assert property (@(posedge clk) disable iff (!rstN)
    (drainWs && drainDone) |=> (!retireLock && statusCode == 3'd1));

  // R5: flush lasts one cycle and only follows the active region
  p_flush_one_cycle_r5: assert property (@(posedge clk) disable iff (!rstN)
    pipeFlush |=> (!pipeFlush && !ckptRestore && !txActive));

  // R9: no flush unless the previous cycle was transactional
  p_flush_source_r9: assert property (@(posedge clk) disable iff (!rstN)
    !txActive |=> !pipeFlush);

  // R6/R7: overflow beats everything, including end
  p_ovf_priority_r7: assert property (@(posedge clk) disable iff (!rstN)
    (txActive && (loadOverflow || storeOverflow)) |=> (pipeFlush && ckptRestore && statusCode == 3'd2));

  // R6: conflict without overflow reports code 3
  p_conflict_code_r6: assert property (@(posedge clk) disable iff (!rstN)
    (txActive && snoopConflict && !loadOverflow && !storeOverflow) |=> (pipeFlush && statusCode == 3'd3));

  // R7: explicit abort beats end
  p_explicit_beats_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    (txActive && abortReq && endReq) |=> (pipeFlush && !drainWs));

endmodule

bind htm_txn_ctrl htm_txn_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .endReq(endReq), .abortReq(abortReq),
  .inflightCnt(inflightCnt),
  .loadOverflow(loadOverflow), .storeOverflow(storeOverflow),
  .snoopConflict(snoopConflict), .drainDone(drainDone),
  .dispatchStall(dispatchStall), .retireLock(retireLock),
  .memBufLock(memBufLock), .drainWs(drainWs),
  .pipeFlush(pipeFlush), .ckptRestore(ckptRestore),
  .txActive(txActive), .statusCode(statusCode)
);

// File: tb/htm_txn_ctrl_tb_top.sv
module htm_txn_ctrl_tb_top;

  localparam int ROB_SIZE  = 168;
  localparam int DEPTH_MAX = 3;
  localparam int CNT_W     = $clog2(ROB_SIZE + 1);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             beginReq = 1'b0, endReq = 1'b0, abortReq = 1'b0;
  logic [CNT_W-1:0] inflightCnt = '0;
  logic             loadBufEmpty = 1'b1, storeBufEmpty = 1'b1;
  logic             loadOverflow = 1'b0, storeOverflow = 1'b0;
  logic             snoopConflict = 1'b0, drainDone = 1'b0;
  logic             dispatchStall, retireLock, memBufLock, drainWs;
  logic             pipeFlush, ckptRestore, txActive;
  logic [2:0]       statusCode;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  htm_txn_ctrl #(.ROB_SIZE(ROB_SIZE), .DEPTH_MAX(DEPTH_MAX)) dut_i (
    .clk(clk), .rstN(rstN),
    .beginReq(beginReq), .endReq(endReq), .abortReq(abortReq),
    .inflightCnt(inflightCnt),
    .loadBufEmpty(loadBufEmpty), .storeBufEmpty(storeBufEmpty),
    .loadOverflow(loadOverflow), .storeOverflow(storeOverflow),
    .snoopConflict(snoopConflict), .drainDone(drainDone),
    .dispatchStall(dispatchStall), .retireLock(retireLock),
    .memBufLock(memBufLock), .drainWs(drainWs),
    .pipeFlush(pipeFlush), .ckptRestore(ckptRestore),
    .txActive(txActive), .statusCode(statusCode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // packs the seven control outputs: stall,rlock,mlock,drain,flush,restore,active
  function automatic int outs();
    return {25'd0, dispatchStall, retireLock, memBufLock, drainWs,
            pipeFlush, ckptRestore, txActive};
  endfunction

  task automatic clearAborts();
    loadOverflow = 0; storeOverflow = 0; snoopConflict = 0; abortReq = 0;
  endtask

  task automatic goActive();
    inflightCnt = '0; loadBufEmpty = 1; storeBufEmpty = 1;
    beginReq = 1; step(); beginReq = 0;
    chk("R2 stall after begin", outs(), 7'b1000000);
    step();
    chk("R3 active locks", outs(), 7'b0110001);
  endtask

  task automatic finishCommit();
    endReq = 1; step(); endReq = 0;
    chk("R4 drain outputs", outs(), 7'b1111000);
    drainDone = 1; step(); drainDone = 0;
    chk("R4 idle after drain", outs(), 0);
    chk("R4 committed code", statusCode, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    step(); step();
    rstN = 1;
    step();
    // R1: reset state
    chk("R1 outputs after reset", outs(), 0);
    chk("R1 status after reset", statusCode, 0);

    // R9: abort inputs in idle have no effect
    loadOverflow = 1; storeOverflow = 1; snoopConflict = 1; abortReq = 1;
    step(); clearAborts();
    chk("R9 idle ignores aborts", outs(), 0);
    chk("R9 idle status unchanged", statusCode, 0);

    // R2: stall held over every non-zero in-flight count
    inflightCnt = CNT_W'(ROB_SIZE);
    beginReq = 1; step(); beginReq = 0;
    chk("R2 stall asserted", dispatchStall, 1);
    for (int c = ROB_SIZE; c >= 1; c--) begin
      inflightCnt = CNT_W'(c);
      step();
      if (dispatchStall !== 1'b1 || txActive !== 1'b0)
        chk("R2 stall with inflight", outs(), 7'b1000000);
    end
    total++;
    // R2: sweep the empty-condition combinations, only all-clean proceeds;
    // R9: abort inputs are asserted during the wait and must be ignored
    for (int i = 0; i < 7; i++) begin
      inflightCnt   = i[0] ? '0 : CNT_W'(1);
      loadBufEmpty  = i[1];
      storeBufEmpty = i[2];
      loadOverflow = 1; snoopConflict = 1; abortReq = 1;
      step();
      chk("R2 wait combo held", outs(), 7'b1000000);
      chk("R9 no flush during wait", pipeFlush, 0);
    end
    clearAborts();
    inflightCnt = '0; loadBufEmpty = 1; storeBufEmpty = 1;
    step();
    chk("R2 active after clean window", outs(), 7'b0110001);
    chk("R10 status cleared on begin", statusCode, 0);

    // R4/R9: commit with slow drain and conflicts ignored during drain
    endReq = 1; step(); endReq = 0;
    for (int k = 0; k < 3; k++) begin
      snoopConflict = 1; storeOverflow = 1;
      step();
      chk("R9 drain ignores aborts", outs(), 7'b1111000);
    end
    clearAborts();
    drainDone = 1; step(); drainDone = 0;
    chk("R4 idle after commit", outs(), 0);
    chk("R4 commit code", statusCode, 1);
    // R10: status holds in idle
    step(); step();
    chk("R10 status held", statusCode, 1);

    // R5/R6/R7: every abort-cause combination, with and without end
    for (int m = 1; m < 16; m++) begin
      if ((m & 7) == 0) continue;
      goActive();
      loadOverflow  = m[0];
      snoopConflict = m[1];
      abortReq      = m[2];
      endReq        = m[3];
      step(); clearAborts(); endReq = 0;
      chk("R5 flush cycle", outs(), 7'b1000110);
      chk("R6 abort code", statusCode, m[0] ? 2 : (m[1] ? 3 : 4));
      step();
      chk("R5 idle after flush", outs(), 0);
      chk("R7 no drain after abort", drainWs, 0);
    end
    // R6: store-buffer overflow also reports code 2
    goActive();
    storeOverflow = 1; step(); clearAborts();
    chk("R6 store overflow code", statusCode, 2);
    step();

    // R8: nesting at every depth up to DEPTH_MAX
    for (int n = 1; n <= DEPTH_MAX; n++) begin
      goActive();
      for (int b = 1; b < n; b++) begin
        beginReq = 1; step(); beginReq = 0;
        chk("R8 nested begin stays active", outs(), 7'b0110001);
      end
      // begin and end together leave depth unchanged
      beginReq = 1; endReq = 1; step(); beginReq = 0; endReq = 0;
      chk("R8 begin+end no change", outs(), 7'b0110001);
      for (int e = 1; e < n; e++) begin
        endReq = 1; step(); endReq = 0;
        chk("R8 inner end stays active", outs(), 7'b0110001);
      end
      finishCommit();
    end
    // R8: nest overflow aborts with code 2
    goActive();
    for (int b = 1; b < DEPTH_MAX; b++) begin
      beginReq = 1; step(); beginReq = 0;
    end
    chk("R8 at max still active", txActive, 1);
    beginReq = 1; step(); beginReq = 0;
    chk("R8 nest overflow flush", outs(), 7'b1000110);
    chk("R8 nest overflow code", statusCode, 2);
    step();
    chk("R8 idle after nest overflow", outs(), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule